// File: doc/BRIEF.md
# External Memory Port Bus Controller

This block produces the control strobes of a processor's external memory port. The core presents one access at a time with a valid/ready handshake. Each access names an address space (program, X data or Y data), a direction and a vector-fetch flag. The block turns each access into active-low select, read and write strobes. It also produces output-enable signals for the address, data and control pins, which the pad ring uses to tri-state them.

One shared input and one shared output change role under a mode input. With the mode clear, the input is an active-low bus request from an external master. The request is sampled only on the core's instruction-boundary pulse. The port is then released and the output is driven low as a grant. With the mode set, the input is an active-low wait that stretches the access on the port. The output is then an active-low bus strobe that marks each access on the port.

Top module: `ext_port_ctl`

## Requirements
- R1: While `rst_n` is low, `ctl_oe`, `addr_oe`, `data_oe` and `acc_ready` are 0, `bgnt_strb_n` is 1 and every strobe is 1; the first cycle after reset shows the port owned and idle.
- R2: The `acc_space` encoding is 0 = program, 1 = X data, 2 = Y data, and 3 behaves as Y data. During an access on the port, `prog_sel_n` is 0 for program accesses and `data_sel_n` is 0 for every other space.
- R3: During an access on the port, `xy_sel_n` is 0 for a Y data access (space 2 or 3). It is also 0 for an access with `acc_vector` set while `dev_mode` is 1, and is 1 otherwise.
- R4: `rd_en_n` is 0 during a read access and `wr_en_n` is 0 during a write access; they are never 0 together. `data_oe` is 1 only during a write access.
- R5: An access is accepted at a clock edge where `acc_valid` and `acc_ready` are both 1. Its strobes show from the following cycle. Without wait states, accesses follow back to back at one per cycle.
- R6: With `share_mode` 0, `brq_wait_n` is acted on only in a cycle where `insn_boundary` is 1. In that cycle `acc_ready` is 0, and from the next cycle `ctl_oe` and `addr_oe` are 0 with all strobes 1.
- R7: With `share_mode` 0, `bgnt_strb_n` goes to 0 one cycle after the pins were tri-stated, provided the request is still present. It is never 0 while `ctl_oe` is 1.
- R8: While the port is released, `acc_ready` stays 0 and no new access starts.
- R9: Once the request is removed during grant, `bgnt_strb_n` returns to 1 in the next cycle. One cycle later the pins are driven again and `acc_ready` returns to 1. If the request is removed before the grant, the grant is skipped.
- R10: With `share_mode` 1, every cycle in which `brq_wait_n` is 0 has `acc_ready` at 0 and keeps the access on the port unchanged. A request on the shared input does not release the port in this mode.
- R11: With `share_mode` 1, `bgnt_strb_n` is 0 exactly in the cycles where an access is on the port.
- R12: Accesses reach the port in the order they were accepted, and each access appears once, also across wait states and bus release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| share_mode | input | 1 | 0: shared pins are request/grant; 1: wait/bus strobe |
| dev_mode | input | 1 | Development mode: vector fetches drive `xy_sel_n` low |
| insn_boundary | input | 1 | Pulse from the core at an instruction boundary |
| acc_valid | input | 1 | Core has an external access to issue |
| acc_space | input | 2 | 0 program, 1 X data, 2 Y data, 3 as Y data |
| acc_write | input | 1 | 1 write, 0 read |
| acc_vector | input | 1 | Access is an exception vector fetch |
| acc_ready | output | 1 | Access can be accepted this cycle |
| brq_wait_n | input | 1 | Shared input: bus request or wait, active low |
| bgnt_strb_n | output | 1 | Shared output: bus grant or bus strobe, active low |
| prog_sel_n | output | 1 | Program memory select, active low |
| data_sel_n | output | 1 | Data memory select, active low |
| xy_sel_n | output | 1 | X/Y select, low for Y |
| rd_en_n | output | 1 | Read enable, active low |
| wr_en_n | output | 1 | Write enable, active low |
| ctl_oe | output | 1 | Output enable for the control strobes |
| addr_oe | output | 1 | Output enable for the address pins |
| data_oe | output | 1 | Output enable for the data pins |

## Verification
`acc_ready` is combinational and depends on the shared input and the boundary pulse in the same cycle. The strobes of an accepted access appear one cycle after the accepting edge. A release request seen at a boundary edge drops the enables one cycle later, and the grant follows one cycle after that. Removing the request raises the grant one cycle later, and the pins are driven again one cycle after that. The bench drives inputs on the falling edge and compares every output shortly after it against a behavioural model. The model advances on the rising edge from the same inputs, so each result is compared in the cycle in which it is due.

// File: rtl/epc_pkg.sv
`timescale 1ns/1ps
package epc_pkg;

  typedef enum logic [1:0] {
    SP_PROG  = 2'd0,
    SP_XDATA = 2'd1,
    SP_YDATA = 2'd2,
    SP_YALT  = 2'd3
  } space_e;

  typedef struct packed {
    space_e space;
    logic   write;
    logic   vector;
  } access_t;

  typedef enum logic [1:0] {
    ARB_OWN      = 2'd0,
    ARB_RELEASED = 2'd1,
    ARB_GRANTED  = 2'd2,
    ARB_RETURN   = 2'd3
  } arb_e;

  // Space decoding, kept here so every module reads it the same way.
  function automatic logic f_is_prog(input access_t a);
    return a.space == SP_PROG;
  endfunction

  function automatic logic f_is_ydata(input access_t a);
    return (a.space == SP_YDATA) || (a.space == SP_YALT);
  endfunction

  function automatic logic f_xy_low(input access_t a, input logic dev);
    return f_is_ydata(a) || (a.vector && dev);
  endfunction

  // Shared input acts as a wait only when the mode bit is set.
  function automatic logic f_wait_active(input logic mode, input logic in_n);
    return mode && !in_n;
  endfunction

  // A request counts only in request/grant mode at an instruction boundary.
  function automatic logic f_release_req(input logic mode, input logic in_n,
                                         input logic boundary);
    return !mode && !in_n && boundary;
  endfunction

  function automatic arb_e f_arb_next(input arb_e st, input logic mode,
                                      input logic in_n, input logic rel);
    arb_e nx;
    nx = st;
    case (st)
      ARB_OWN:      if (rel) nx = ARB_RELEASED;
      ARB_RELEASED: nx = (mode || in_n) ? ARB_RETURN : ARB_GRANTED;
      ARB_GRANTED:  if (mode || in_n) nx = ARB_RETURN;
      ARB_RETURN:   nx = ARB_OWN;
      default:      nx = ARB_OWN;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/epc_arbiter.sv
`timescale 1ns/1ps
module epc_arbiter
  import epc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic share_mode,
  input  logic share_in_n,
  input  logic insn_boundary,
  output logic port_owned,
  output logic release_now,
  output logic grant_on
);

  arb_e state_q;
  arb_e state_d;

  assign port_owned  = rst_n && (state_q == ARB_OWN);
  assign release_now = port_owned &&
                       f_release_req(share_mode, share_in_n, insn_boundary);
  assign grant_on    = rst_n && (state_q == ARB_GRANTED);
  assign state_d     = f_arb_next(state_q, share_mode, share_in_n, release_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_OWN;
    else        state_q <= state_d;
  end

  AST_RELEASE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_RELEASED) |-> ($past(insn_boundary) && !$past(share_mode))) // R6
    else $error("release without boundary");

  AST_GRANT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_on |-> ($past(state_q) != ARB_OWN)) // R7
    else $error("grant before release");

  AST_RETURN_BEFORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ARB_OWN) && ($past(state_q) != ARB_OWN)) |-> ($past(state_q) == ARB_RETURN)) // R9
    else $error("pins driven without return step");

endmodule

// File: rtl/epc_sequencer.sv
`timescale 1ns/1ps
module epc_sequencer
  import epc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_ok,
  input  logic    hold,
  input  logic    req_valid,
  input  access_t req,
  output access_t cur,
  output logic    cur_valid,
  output logic    accept,
  output logic    retire
);

  assign accept = req_valid && start_ok;
  assign retire = cur_valid && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur       <= '0;
    end else if (accept) begin
      cur_valid <= 1'b1;
      cur       <= req;
    end else if (retire) begin
      cur_valid <= 1'b0;
    end
  end

  AST_WAIT_HOLDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && hold) |=> (cur_valid && $stable(cur))) // R10
    else $error("access left port during wait");

  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ok && !cur_valid) |=> !cur_valid) // R8
    else $error("access started while blocked");

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!cur_valid || retire)) // R12
    else $error("accept overtook access in flight");

endmodule

// File: rtl/epc_pins.sv
`timescale 1ns/1ps
module epc_pins
  import epc_pkg::*;
(
  input  access_t cur,
  input  logic    cur_valid,
  input  logic    port_owned,
  input  logic    grant_on,
  input  logic    share_mode,
  input  logic    dev_mode,
  output logic    prog_sel_n,
  output logic    data_sel_n,
  output logic    xy_sel_n,
  output logic    rd_en_n,
  output logic    wr_en_n,
  output logic    ctl_oe,
  output logic    addr_oe,
  output logic    data_oe,
  output logic    share_out_n,
  output logic    on_port
);

  assign on_port     = cur_valid && port_owned;
  assign ctl_oe      = port_owned;
  assign addr_oe     = port_owned;
  assign data_oe     = on_port && cur.write;
  assign prog_sel_n  = !(on_port && f_is_prog(cur));
  assign data_sel_n  = !(on_port && !f_is_prog(cur));
  assign xy_sel_n    = !(on_port && f_xy_low(cur, dev_mode));
  assign rd_en_n     = !(on_port && !cur.write);
  assign wr_en_n     = !(on_port && cur.write);
  assign share_out_n = share_mode ? !on_port : !grant_on;

endmodule

// File: rtl/ext_port_ctl.sv
`timescale 1ns/1ps
module ext_port_ctl
  import epc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       share_mode,
  input  logic       dev_mode,
  input  logic       insn_boundary,
  input  logic       acc_valid,
  input  logic [1:0] acc_space,
  input  logic       acc_write,
  input  logic       acc_vector,
  output logic       acc_ready,
  input  logic       brq_wait_n,
  output logic       bgnt_strb_n,
  output logic       prog_sel_n,
  output logic       data_sel_n,
  output logic       xy_sel_n,
  output logic       rd_en_n,
  output logic       wr_en_n,
  output logic       ctl_oe,
  output logic       addr_oe,
  output logic       data_oe
);

  // Named internal events, kept visible for the assertions.
  logic    port_owned;
  logic    release_now;
  logic    grant_on;
  logic    wait_active;
  logic    cur_valid;
  logic    accept;
  logic    retire;
  logic    on_port;
  access_t req;
  access_t cur;

  assign req         = '{space: space_e'(acc_space), write: acc_write, vector: acc_vector};
  assign wait_active = f_wait_active(share_mode, brq_wait_n);
  assign acc_ready   = port_owned && !release_now && !wait_active;

  epc_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .share_mode    (share_mode),
    .share_in_n    (brq_wait_n),
    .insn_boundary (insn_boundary),
    .port_owned    (port_owned),
    .release_now   (release_now),
    .grant_on      (grant_on)
  );

  epc_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (acc_ready),
    .hold      (wait_active),
    .req_valid (acc_valid),
    .req       (req),
    .cur       (cur),
    .cur_valid (cur_valid),
    .accept    (accept),
    .retire    (retire)
  );

  epc_pins u_pins (
    .cur         (cur),
    .cur_valid   (cur_valid),
    .port_owned  (port_owned),
    .grant_on    (grant_on),
    .share_mode  (share_mode),
    .dev_mode    (dev_mode),
    .prog_sel_n  (prog_sel_n),
    .data_sel_n  (data_sel_n),
    .xy_sel_n    (xy_sel_n),
    .rd_en_n     (rd_en_n),
    .wr_en_n     (wr_en_n),
    .ctl_oe      (ctl_oe),
    .addr_oe     (addr_oe),
    .data_oe     (data_oe),
    .share_out_n (bgnt_strb_n),
    .on_port     (on_port)
  );

  AST_RDWR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_en_n && !wr_en_n)) // R4
    else $error("read and write together");

  AST_TRISTATE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!share_mode && !bgnt_strb_n) |-> (!ctl_oe && rd_en_n && wr_en_n && prog_sel_n && data_sel_n)) // R7
    else $error("pins driven during grant");

  AST_STROBE_TRACKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    share_mode |-> (!bgnt_strb_n == (!rd_en_n || !wr_en_n))) // R11
    else $error("bus strobe disagrees with access");

  AST_ACCEPT_SHOWS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (on_port || !ctl_oe)) // R5
    else $error("accepted access missing from port");

  AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!prog_sel_n, !data_sel_n})) // R2
    else $error("both selects low");

endmodule

// File: tb/ext_port_ctl_tb.sv
`timescale 1ns/1ps
module ext_port_ctl_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, mode = 1'b0, dev = 1'b0, ibound = 1'b0, brw_n = 1'b1;
  logic rv = 1'b0, rwr = 1'b0, rvec = 1'b0;
  logic [1:0] rsp = 2'd0;
  logic ready, bgs_n, ps_n, ds_n, xy_n, rd_n, wr_n, c_oe, a_oe, d_oe;

  ext_port_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .share_mode(mode), .dev_mode(dev),
    .insn_boundary(ibound), .acc_valid(rv), .acc_space(rsp),
    .acc_write(rwr), .acc_vector(rvec), .acc_ready(ready),
    .brq_wait_n(brw_n), .bgnt_strb_n(bgs_n), .prog_sel_n(ps_n),
    .data_sel_n(ds_n), .xy_sel_n(xy_n), .rd_en_n(rd_n), .wr_en_n(wr_n),
    .ctl_oe(c_oe), .addr_oe(a_oe), .data_oe(d_oe)
  );

  typedef struct { int sp; bit wr; bit vec; } acc_s;
  acc_s pend[$];           // accesses the core still wants to issue
  logic [4:0] order_q[$];  // expected strobe signatures, in acceptance order

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int   m_arb = 0;         // 0 owned, 1 released, 2 granted, 3 returning
  bit   m_cv = 0;
  acc_s m_cur;

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] sig_of(acc_s a, bit d);
    logic [4:0] s;
    s[4] = !(a.sp == 0);
    s[3] = !(a.sp != 0);
    s[2] = !(a.sp >= 2 || (a.vec && d));
    s[1] = !(!a.wr);
    s[0] = !(a.wr);
    return s;
  endfunction

  task automatic push(int sp, bit wr, bit vec);
    acc_s a;
    a.sp = sp; a.wr = wr; a.vec = vec;
    pend.push_back(a);
  endtask

  task automatic cyc();
    bit owned, reln, waitq, e_ready, act, acc, ret;
    logic [4:0] e_sig;
    string rtag;
    if (pend.size() > 0) begin
      rv = 1; rsp = 2'(pend[0].sp); rwr = pend[0].wr; rvec = pend[0].vec;
    end else begin
      rv = 0;
    end
    #1;
    owned   = rst_n && (m_arb == 0);
    reln    = owned && !mode && ibound && !brw_n;
    waitq   = mode && !brw_n;
    e_ready = owned && !reln && !waitq;
    act     = owned && m_cv;
    e_sig   = act ? sig_of(m_cur, dev) : 5'b11111;
    rtag    = !rst_n ? "R1" : (m_arb != 0 || reln) ? "R8" : waitq ? "R10" : "R5";
    chk(rtag, "acc_ready", ready, e_ready);
    chk(!rst_n ? "R1" : (m_arb == 3 ? "R9" : "R6"), "ctl_oe", c_oe, owned);
    chk(!rst_n ? "R1" : "R6", "addr_oe", a_oe, owned);
    chk(!rst_n ? "R1" : "R4", "data_oe", d_oe, act && m_cur.wr);
    chk(!rst_n ? "R1" : (mode ? "R11" : "R7"), "bgnt_strb_n", bgs_n,
        mode ? !act : !(rst_n && m_arb == 2));
    chk("R2", "prog_sel_n", ps_n, e_sig[4]);
    chk("R2", "data_sel_n", ds_n, e_sig[3]);
    chk("R3", "xy_sel_n", xy_n, e_sig[2]);
    chk("R4", "rd_en_n", rd_n, e_sig[1]);
    chk("R4", "wr_en_n", wr_n, e_sig[0]);
    acc = rv && e_ready;
    ret = act && !waitq;
    if (ret) begin
      if (order_q.size() == 0) chk("R12", "retire without accept", 1'b1, 1'b0);
      else chk("R12", "retire order", ({ps_n, ds_n, xy_n, rd_n, wr_n} == order_q[0]), 1'b1);
      if (order_q.size() > 0) void'(order_q.pop_front());
    end
    @(posedge clk);
    if (!rst_n) begin
      m_arb = 0; m_cv = 0;
    end else begin
      if (acc) begin
        m_cur = pend[0]; m_cv = 1;
        order_q.push_back(sig_of(pend[0], dev));
        void'(pend.pop_front());
      end else if (ret) m_cv = 0;
      case (m_arb)
        0: if (reln) m_arb = 1;
        1: m_arb = (mode || brw_n) ? 3 : 2;
        2: if (mode || brw_n) m_arb = 3;
        default: m_arb = 0;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with a request already offered
    push(0, 0, 0);
    run(3);
    rst_n = 1;
    // R2 R3 R4 R5: back-to-back spaces and directions, development mode off
    push(1, 1, 0); push(2, 0, 0); push(0, 0, 1); push(3, 1, 0);
    run(7);
    // R3: vector fetch with development mode on
    dev = 1;
    push(0, 0, 1); push(1, 0, 1); push(0, 1, 0);
    run(5);
    dev = 0;
    // R6: request without a boundary is ignored
    brw_n = 0;
    push(1, 0, 0); push(2, 1, 0);
    run(4);
    // R6 R7 R8 R9: release at boundary with an access pending, then return
    push(2, 1, 0); push(0, 0, 0);
    ibound = 1; run(1); ibound = 0;
    run(5);
    brw_n = 1;
    run(5);
    // R9: request withdrawn before the grant
    brw_n = 0; ibound = 1; push(1, 1, 0); run(1);
    ibound = 0; brw_n = 1; run(4);
    // R10 R11: wait mode stretches accesses; strobe follows the port
    mode = 1;
    push(0, 0, 0); push(1, 1, 0); push(2, 0, 0);
    run(1);
    brw_n = 0; run(3);
    brw_n = 1; run(1);
    brw_n = 0; run(2);
    brw_n = 1; run(4);
    // R10: boundary pulse with the shared input low does not release in wait mode
    brw_n = 0; ibound = 1; run(1); ibound = 0; brw_n = 1;
    push(3, 0, 0); run(3);
    // R12: everything offered reached the port
    chk("R12", "all accepted", (pend.size() == 0 && order_q.size() == 0), 1'b1);
    // R1: reset in the middle of a grant
    mode = 0; brw_n = 0; ibound = 1; run(1); ibound = 0; run(2);
    rst_n = 0; run(2); brw_n = 1; rst_n = 1; run(2);
    done = 1;
    summary();
    $finish;
  end

endmodule